// File: doc/BRIEF.md
# DMA Request Queue Bank with In-Band Flush

This block keeps the pending external transfer requests of an eight-channel DMA controller. Each request word arrives with a 3-bit channel number. It is stored in that channel's own small FIFO. The transfer engine sees, for each channel, a pending flag and the oldest stored word, and it takes a word by pulsing that channel's pop strobe.

A channel's FIFO can be emptied in two ways. The first is a reserved request word, decoded on the request path, whose channel-select subfield names the channel to flush. The second is a one-shot software write of a per-channel clear bit. A flush touches only the channel it names. A flush-command word is never stored as a request.

Top module: `dma_reqq_bank`

## Requirements
- R1: A request word whose fields do not form a flush command is appended to the FIFO of channel `req_chan`. The FIFO releases words in arrival order. While the FIFO is non-empty, `q_pend[c]` is 1 and `deq_head[c*32 +: 32]` shows the oldest word.
- R2: A pulse on `deq_pop[c]` while channel c is non-empty removes the oldest word. The next word, or an empty state, is visible after that clock edge.
- R3: Each FIFO holds 4 words, and `q_full[c]` is 1 when it holds 4. A word sent to a full channel is discarded and sets `q_ovf[c]`. This flag stays at 1 until reset, even when a pop happens in the same cycle.
- R4: A word is a flush command when bits [31:29] = 3'b110, bits [28:27] = 2'b00 and bits [25:24] = 2'b11. If bits [23:20] hold a value n from 1 to 8, the FIFO of channel n-1 is emptied.
- R5: A flush command whose bits [23:20] are 0 or 9 to 15 changes nothing. No flush command is ever stored in any FIFO.
- R6: When `sw_clr_we` is 1, every channel whose `sw_clr_mask` bit is 1 is emptied. The clear acts only in that cycle, so words enqueued afterwards are kept.
- R7: A flush leaves the contents of every channel it does not name unchanged.
- R8: When a flush and an enqueue or pop hit the same channel in one cycle, the flush wins. The channel ends empty, and its overflow flag is unaffected by that enqueue.
- R9: After reset, all channels are empty and no overflow flag is set.
- R10: A word that differs from the flush pattern in any one of the size, ID or mode fields is an ordinary request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word present this cycle |
| req_chan | input | 3 | Channel number carried with the request |
| req_word | input | 32 | Request word |
| sw_clr_we | input | 1 | Software clear-bit write strobe |
| sw_clr_mask | input | 8 | Per-channel clear bits written |
| deq_pop | input | 8 | Per-channel pop strobes from the transfer engine |
| deq_head | output | 256 | Oldest word of each channel, channel c at [c*32 +: 32] |
| q_pend | output | 8 | Channel FIFO non-empty |
| q_full | output | 8 | Channel FIFO holds 4 words |
| q_ovf | output | 8 | Sticky drop-on-full flag |

## Verification
Every effect of an input appears exactly one clock edge later: enqueue, pop, flush and overflow are all registered at that edge, and the head word follows the stored state combinationally. The bench drives inputs on the falling edge and advances its own queue model at the rising edge. It compares every flag and every non-empty head word at the following falling edge, so each result is checked in the first cycle it is due. Directed checks placed after particular stimuli (fill, flush command, out-of-range count, near-miss words, software clear, same-cycle conflicts) sample at that same point.

// File: rtl/dma_rq_pkg.sv
package dma_rq_pkg;
  localparam int WORD_W = 32;
  localparam logic [2:0] FLUSH_SIZE = 3'b110;
  localparam logic [1:0] FLUSH_ID   = 2'b00;
  localparam logic [1:0] FLUSH_MODE = 2'b11;

  // Reserved encoding: size [31:29], id [28:27], mode [25:24]
  function automatic logic is_flush_word(input logic [WORD_W-1:0] w);
    return (w[31:29] == FLUSH_SIZE) && (w[28:27] == FLUSH_ID) &&
           (w[25:24] == FLUSH_MODE);
  endfunction

  // Channel-select subfield of a flush word
  function automatic logic [3:0] flush_sel(input logic [WORD_W-1:0] w);
    return w[23:20];
  endfunction

  // Selector value n in 1..8 names channel n-1; -1 means no target
  function automatic int flush_target(input logic [3:0] sel);
    if (sel >= 4'd1 && sel <= 4'd8) return int'(sel) - 1;
    return -1;
  endfunction
endpackage

// File: rtl/dma_rq_decode.sv
module dma_rq_decode
  import dma_rq_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [WORD_W-1:0] req_word,
  input  logic              sw_clr_we,
  input  logic [NUM_CH-1:0] sw_clr_mask,
  output logic [NUM_CH-1:0] enq_vec,
  output logic [NUM_CH-1:0] cmd_clr_vec,
  output logic [NUM_CH-1:0] clr_vec,
  output logic              cmd_seen
);
  int tgt;

  always_comb begin
    cmd_seen    = req_valid && is_flush_word(req_word);
    tgt         = flush_target(flush_sel(req_word));
    enq_vec     = '0;
    cmd_clr_vec = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_valid && !cmd_seen && (req_chan == CH_W'(i))) enq_vec[i] = 1'b1;
      if (cmd_seen && (tgt == i)) cmd_clr_vec[i] = 1'b1;
    end
    clr_vec = cmd_clr_vec | (sw_clr_we ? sw_clr_mask : '0);
  end
endmodule

// File: rtl/dma_rq_fifo.sv
module dma_rq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop, ovf_evt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign ovf_evt = push && full && !flush;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (ovf_evt) ovf <= 1'b1;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        cnt    <= '0;
      end else begin
        if (do_push) wr_ptr <= ptr_next(wr_ptr);
        if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
        cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
    end
  end
endmodule

// File: rtl/dma_reqq_bank.sv
module dma_reqq_bank
  import dma_rq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DEPTH  = 4,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [CH_W-1:0]          req_chan,
  input  logic [WORD_W-1:0]        req_word,
  input  logic                     sw_clr_we,
  input  logic [NUM_CH-1:0]        sw_clr_mask,
  input  logic [NUM_CH-1:0]        deq_pop,
  output logic [NUM_CH*WORD_W-1:0] deq_head,
  output logic [NUM_CH-1:0]        q_pend,
  output logic [NUM_CH-1:0]        q_full,
  output logic [NUM_CH-1:0]        q_ovf
);
  logic [NUM_CH-1:0] enq_vec, cmd_clr_vec, clr_vec;
  logic              cmd_seen;

  dma_rq_decode #(.NUM_CH(NUM_CH)) u_dec (
    .req_valid  (req_valid),
    .req_chan   (req_chan),
    .req_word   (req_word),
    .sw_clr_we  (sw_clr_we),
    .sw_clr_mask(sw_clr_mask),
    .enq_vec    (enq_vec),
    .cmd_clr_vec(cmd_clr_vec),
    .clr_vec    (clr_vec),
    .cmd_seen   (cmd_seen)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic empty_c;
    dma_rq_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (enq_vec[c]),
      .din  (req_word),
      .pop  (deq_pop[c]),
      .flush(clr_vec[c]),
      .head (deq_head[c*WORD_W +: WORD_W]),
      .empty(empty_c),
      .full (q_full[c]),
      .ovf  (q_ovf[c])
    );
    assign q_pend[c] = !empty_c;
  end
endmodule

// File: rtl/dma_reqq_chk.sv
module dma_reqq_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] q_pend,
  input logic [NUM_CH-1:0] q_full,
  input logic [NUM_CH-1:0] q_ovf,
  input logic [NUM_CH-1:0] deq_pop,
  input logic [NUM_CH-1:0] enq_vec,
  input logic [NUM_CH-1:0] cmd_clr_vec,
  input logic [NUM_CH-1:0] clr_vec,
  input logic              cmd_seen
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((q_pend & $past(clr_vec)) == '0)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_clr_vec)); // R4
  AST_CMD_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_seen |=> ((q_pend & ~$past(q_pend)) == '0)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q_ovf & $past(q_ovf)) == $past(q_ovf))); // R3
  AST_FULL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_full & ~q_pend) == '0)); // R3
  AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (|(enq_vec & q_full & ~clr_vec)) |=>
      ((q_ovf & $past(enq_vec & q_full & ~clr_vec)) ==
       $past(enq_vec & q_full & ~clr_vec))); // R3
  AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_vec) && (deq_pop == '0)) |=>
      ((~q_pend & $past(q_pend & ~clr_vec)) == '0)); // R7
endmodule

bind dma_reqq_bank dma_reqq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_pend     (q_pend),
  .q_full     (q_full),
  .q_ovf      (q_ovf),
  .deq_pop    (deq_pop),
  .enq_vec    (enq_vec),
  .cmd_clr_vec(cmd_clr_vec),
  .clr_vec    (clr_vec),
  .cmd_seen   (cmd_seen)
);

// File: tb/dma_reqq_bank_test.sv
`timescale 1ns/100ps
module dma_reqq_bank_test;
  localparam int NCH = 8;
  localparam int DEP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [2:0]      req_chan = '0;
  logic [31:0]     req_word = '0;
  logic            sw_clr_we = 1'b0;
  logic [NCH-1:0]  sw_clr_mask = '0;
  logic [NCH-1:0]  deq_pop = '0;
  logic [NCH*32-1:0] deq_head;
  logic [NCH-1:0]  q_pend, q_full, q_ovf;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mq [NCH][$];
  bit          movf [NCH];

  always #2.5 clk = ~clk;

  dma_reqq_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_word(req_word), .sw_clr_we(sw_clr_we), .sw_clr_mask(sw_clr_mask),
    .deq_pop(deq_pop), .deq_head(deq_head), .q_pend(q_pend),
    .q_full(q_full), .q_ovf(q_ovf)
  );

  function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endfunction

  function automatic bit flush_pat(logic [31:0] w);
    return w[31:29] == 3'b110 && w[28:27] == 2'b00 && w[25:24] == 2'b11;
  endfunction

  function automatic logic [31:0] flush_cmd(logic [3:0] n);
    return {3'b110, 2'b00, 1'b0, 2'b11, n, 20'h0};
  endfunction

  // Behavioural reference: one SV queue per channel
  task automatic model_step();
    int tgt;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin mq[c].delete(); movf[c] = 0; end
      return;
    end
    tgt = -1;
    if (req_valid && flush_pat(req_word) && req_word[23:20] >= 1 && req_word[23:20] <= 8)
      tgt = int'(req_word[23:20]) - 1;
    for (int c = 0; c < NCH; c++) begin
      bit clr, push, was_full;
      clr  = (sw_clr_we && sw_clr_mask[c]) || (tgt == c);
      push = req_valid && !flush_pat(req_word) && (int'(req_chan) == c);
      was_full = (mq[c].size() == DEP);
      if (clr) mq[c].delete();
      else begin
        if (deq_pop[c] && mq[c].size() > 0) void'(mq[c].pop_front());
        if (push) begin
          if (was_full) movf[c] = 1;
          else mq[c].push_back(req_word);
        end
      end
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) begin
      check(q_pend[c] == (mq[c].size() > 0), "R1 pend", 32'(q_pend[c]), 32'(mq[c].size() > 0));
      check(q_full[c] == (mq[c].size() == DEP), "R3 full", 32'(q_full[c]), 32'(mq[c].size() == DEP));
      check(q_ovf[c] == movf[c], "R3 ovf", 32'(q_ovf[c]), 32'(movf[c]));
      if (mq[c].size() > 0)
        check(deq_head[c*32 +: 32] == mq[c][0], "R1 head", deq_head[c*32 +: 32], mq[c][0]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    req_valid = 0; sw_clr_we = 0; sw_clr_mask = '0; deq_pop = '0;
  endtask

  task automatic send(int ch, logic [31:0] w);
    req_valid = 1; req_chan = 3'(ch); req_word = w;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(q_pend == 0 && q_ovf == 0 && q_full == 0, "R9 reset", 32'(q_pend | q_ovf), 0);

    // R1 / R3: fill ch0 past capacity
    for (int i = 0; i < 5; i++) send(0, 32'h1000_0000 + i);
    check(q_full[0] && q_ovf[0], "R3 full+ovf", 32'({q_full[0], q_ovf[0]}), 3);
    check(deq_head[31:0] == 32'h1000_0000, "R1 oldest first", deq_head[31:0], 32'h1000_0000);

    // R2 pop advances head
    deq_pop[0] = 1; tick();
    check(deq_head[31:0] == 32'h1000_0001, "R2 pop", deq_head[31:0], 32'h1000_0001);

    // R3 pop and push to full in same cycle: sticky flag stays
    send(0, 32'h1000_0009);
    deq_pop[0] = 1; req_valid = 1; req_chan = 0; req_word = 32'h1000_000A; tick();
    check(q_ovf[0] == 1, "R3 sticky", 32'(q_ovf[0]), 1);

    // R7 setup: ch3 has data
    send(3, 32'h3333_0001);
    // R4 flush command count=1 targets ch0
    send(5, flush_cmd(4'd1));
    check(q_pend[0] == 0, "R4 flush ch0", 32'(q_pend[0]), 0);
    check(q_pend[3] == 1, "R7 ch3 kept", 32'(q_pend[3]), 1);
    check(q_ovf[0] == 1, "R3 ovf survives flush", 32'(q_ovf[0]), 1);

    // R4 count=8 targets ch7
    send(7, 32'h7777_0001);
    send(2, flush_cmd(4'd8));
    check(q_pend[7] == 0, "R4 flush ch7", 32'(q_pend[7]), 0);

    // R5 out-of-range selectors: no effect, not stored
    send(3, flush_cmd(4'd0));
    send(3, flush_cmd(4'd9));
    send(4, flush_cmd(4'd15));
    check(q_pend[3] == 1 && q_pend[4] == 0, "R5 no-op", 32'(q_pend), 32'h08);

    // R10 near-miss words are ordinary
    send(1, flush_cmd(4'd2) ^ 32'h2000_0000);
    send(1, flush_cmd(4'd2) ^ 32'h0800_0000);
    send(1, flush_cmd(4'd2) ^ 32'h0100_0000);
    check(q_pend[1] == 1, "R10 near-miss stored", 32'(q_pend[1]), 1);

    // R6 software clear, then self-clearing
    sw_clr_we = 1; sw_clr_mask = 8'h02; tick();
    check(q_pend[1] == 0 && q_pend[3] == 1, "R6 sw clear", 32'(q_pend), 32'h08);
    send(1, 32'hABCD_0001);
    check(q_pend[1] == 1, "R6 self-clear", 32'(q_pend[1]), 1);

    // R8 clear wins over enqueue to a full channel
    for (int i = 0; i < 4; i++) send(6, 32'h6666_0000 + i);
    sw_clr_we = 1; sw_clr_mask = 8'h40; req_valid = 1; req_chan = 6;
    req_word = 32'h6666_00FF; deq_pop[6] = 1; tick();
    check(q_pend[6] == 0 && q_ovf[6] == 0, "R8 clear wins", 32'({q_pend[6], q_ovf[6]}), 0);

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 55) begin
        req_valid = 1; req_chan = 3'($urandom_range(0, 7)); req_word = $urandom;
      end else if (r < 65) begin
        req_valid = 1; req_chan = 3'($urandom_range(0, 7));
        req_word = flush_cmd(4'($urandom_range(0, 15))) | 32'($urandom_range(0, 1) << 26);
      end
      if ($urandom_range(0, 19) == 0) begin
        sw_clr_we = 1; sw_clr_mask = 8'($urandom);
      end
      deq_pop = 8'($urandom) & 8'($urandom);
      tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule